// File: doc/BRIEF.md
# Per-Word Write Action Control

This block keeps a 5-bit action mask for every 32-bit word of a shared memory and turns each data write into the actions that the mask selects. A write can arrive from the local host or from the network side. Depending on the target word's mask, the write produces a receive interrupt request, a transmit interrupt request, one of two external trigger pulses, or a high-priority hit pulse. The shared memory is outside the block. The block steers accesses onto that memory's single port, and it holds and decodes the masks.

The host reaches everything through one word-addressed window. While `field_mode` is low, host reads and writes go to the shared memory. While it is high, the same addresses reach the mask store: the mask sits in bits 4:0 of the word at that address, and the memory cannot be reached. Masks written in this mode stay in force after `field_mode` is cleared. Network writes always go to memory and are decoded against the masks in either mode.

A steering state machine has three states. `ST_IDLE` accepts a host access. The transition `IDLE_TO_MEM_RD` is taken on an accepted read while `field_mode` is low, and `IDLE_TO_FLD_RD` is taken on an accepted read while it is high. In `ST_MEM_RD` and `ST_FLD_RD` the read data is presented, and `RD_TO_IDLE` returns the machine to `ST_IDLE` one cycle later. Writes are accepted in `ST_IDLE` without leaving it.

Top module: `word_action_ctl`

## Requirements
- R1: After reset every mask is 0, all action outputs are low, and `host_ready` is high.
- R2: With `field_mode` high, a host write with `host_be[0]` set stores `host_wdata[4:0]` as that word's mask. A write with `host_be[0]` clear leaves the mask unchanged. A host read returns the mask in bits 4:0 with zeros above, with `host_rvalid` high in the cycle after acceptance.
- R3: With `field_mode` high, a host access never drives `mem_en`. Only a network write uses the memory port.
- R4: With `field_mode` low, an accepted host access is placed on the memory port in its accept cycle. A read returns `mem_rdata` with `host_rvalid` high for exactly the one cycle after acceptance.
- R5: One cycle after a network data write to a word whose mask bit 0 is set, `act_irq_rx` pulses for one cycle. One cycle after a host data write to a word whose mask bit 1 is set, `act_irq_tx` pulses for one cycle.
- R6: Mask bit 2 drives `act_trig_a` and mask bit 3 drives `act_trig_b`. Each is a one-cycle pulse, one cycle after every data write from either source, and the outputs stay low in any cycle that follows no data write.
- R7: Mask bit 4 drives a one-cycle `act_prio` pulse, one cycle after every data write from either source to that word.
- R8: While `irq_override` is high, the interrupt pulse of R5 fires for a qualifying source regardless of mask bits 0 and 1. The override has no effect on triggers or `act_prio`.
- R9: Once `field_mode` is low, masks still select actions, while host reads return memory data rather than masks.
- R10: A network write (`net_we`) takes the memory port. While it is present and `field_mode` is low, `host_ready` is low. With `field_mode` high, the host is not held off.
- R11: When a host mask write and a network data write to the same word fall in one cycle, the network write is decoded against the mask held before that cycle, and the new mask governs later writes.
- R12: A data write counts only when at least one byte enable is set. A write with all enables clear fires no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_mode | input | 1 | High: the host window reaches the masks |
| irq_override | input | 1 | Global override that forces interrupt requests |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | IDX_W | Host word address |
| host_be | input | 4 | Host byte enables, bit 0 = least significant byte |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Host access accepted this cycle if requested |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 32 | Host read data |
| net_we | input | 1 | Network write strobe |
| net_addr | input | IDX_W | Network word address |
| net_be | input | 4 | Network byte enables |
| net_wdata | input | 32 | Network write data |
| mem_en | output | 1 | Shared memory port enable |
| mem_we | output | 1 | Shared memory write |
| mem_addr | output | IDX_W | Shared memory word address |
| mem_be | output | 4 | Shared memory byte enables |
| mem_wdata | output | 32 | Shared memory write data |
| mem_rdata | input | 32 | Shared memory read data, one cycle after a read |
| act_irq_rx | output | 1 | Receive interrupt request pulse |
| act_irq_tx | output | 1 | Transmit interrupt request pulse |
| act_trig_a | output | 1 | External trigger A pulse |
| act_trig_b | output | 1 | External trigger B pulse |
| act_prio | output | 1 | High-priority word hit pulse |

## Verification
Two functions can fall in the same cycle: a host mask update in field mode and a network data write that must be decoded against a mask. The bench provokes this with a directed write of a new mask to a word while a network write targets the same word. It also mixes the two at random over a small set of words, so collisions keep recurring. The network's actions are judged against the bench's record of the mask as it stood before that cycle, and a following network write is judged against the new mask. The related memory-port contention in normal mode is judged by the state of `host_ready` and by the absence of any host effect.

// File: rtl/wac_pkg.sv
package wac_pkg;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int FLD_W   = 5;
    localparam int FB_RX   = 0;
    localparam int FB_TX   = 1;
    localparam int FB_TA   = 2;
    localparam int FB_TB   = 3;
    localparam int FB_PRIO = 4;

    typedef logic [FLD_W-1:0] field_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MEM_RD = 2'd1,
        ST_FLD_RD = 2'd2
    } steer_state_t;
endpackage

// File: rtl/wac_field_store.sv
module wac_field_store
    import wac_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  field_t           wr_val,
    input  logic [IDX_W-1:0] rd_a_idx,
    output field_t           rd_a_val,
    input  logic [IDX_W-1:0] rd_b_idx,
    output field_t           rd_b_val
);
    field_t cells [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_cell
        field_t q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                q <= wr_val;
            end
        end
        assign cells[g] = q;
    end

    // Reads see the value held before a same-cycle write.
    assign rd_a_val = cells[rd_a_idx];
    assign rd_b_val = cells[rd_b_idx];
endmodule

// File: rtl/wac_access_steer.sv
module wac_access_steer
    import wac_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_mode,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [LANES-1:0]  host_be,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              net_we,
    input  logic [IDX_W-1:0]  net_addr,
    input  logic [LANES-1:0]  net_be,
    input  logic [DATA_W-1:0] net_wdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  field_t            fld_host_val,
    output logic              fld_wr_en,
    output field_t            fld_wr_val,
    output logic              host_data_wr,
    output logic              net_data_wr
);
    steer_state_t state_q, state_d;
    field_t       fld_rd_q;
    logic         accept;

    // Ready depends on the state and on the memory port being free.
    assign host_ready = (state_q == ST_IDLE) && (field_mode || !net_we);
    assign accept     = host_req && host_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !host_we) begin
                    state_d = field_mode ? ST_FLD_RD : ST_MEM_RD;  // IDLE_TO_FLD_RD / IDLE_TO_MEM_RD
                end
            end
            ST_MEM_RD: state_d = ST_IDLE;                          // RD_TO_IDLE
            ST_FLD_RD: state_d = ST_IDLE;                          // RD_TO_IDLE
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            fld_rd_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept && !host_we && field_mode) begin
                fld_rd_q <= fld_host_val;
            end
        end
    end

    always_comb begin
        host_rvalid = 1'b0;
        host_rdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MEM_RD: begin
                host_rvalid = 1'b1;
                host_rdata  = mem_rdata;
            end
            ST_FLD_RD: begin
                host_rvalid = 1'b1;
                host_rdata  = {{(DATA_W-FLD_W){1'b0}}, fld_rd_q};
            end
            default: ;
        endcase
    end

    // Memory port: the network owns it whenever it writes.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = host_addr;
        mem_be    = host_be;
        mem_wdata = host_wdata;
        if (net_we) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = net_addr;
            mem_be    = net_be;
            mem_wdata = net_wdata;
        end else if (accept && !field_mode) begin
            mem_en = 1'b1;
            mem_we = host_we;
        end
    end

    assign fld_wr_en    = accept && host_we && field_mode && host_be[0];
    assign fld_wr_val   = host_wdata[FLD_W-1:0];
    assign host_data_wr = accept && host_we && !field_mode && (|host_be);
    assign net_data_wr  = net_we && (|net_be);
endmodule

// File: rtl/wac_action_decode.sv
module wac_action_decode
    import wac_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   irq_override,
    input  logic   host_v,
    input  field_t host_fld,
    input  logic   net_v,
    input  field_t net_fld,
    output logic   act_irq_rx,
    output logic   act_irq_tx,
    output logic   act_trig_a,
    output logic   act_trig_b,
    output logic   act_prio
);
    logic rx_d, tx_d, ta_d, tb_d, pr_d;

    always_comb begin
        rx_d = net_v  && (net_fld[FB_RX]  || irq_override);
        tx_d = host_v && (host_fld[FB_TX] || irq_override);
        ta_d = (net_v && net_fld[FB_TA])   || (host_v && host_fld[FB_TA]);
        tb_d = (net_v && net_fld[FB_TB])   || (host_v && host_fld[FB_TB]);
        pr_d = (net_v && net_fld[FB_PRIO]) || (host_v && host_fld[FB_PRIO]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_irq_rx <= 1'b0;
            act_irq_tx <= 1'b0;
            act_trig_a <= 1'b0;
            act_trig_b <= 1'b0;
            act_prio   <= 1'b0;
        end else begin
            act_irq_rx <= rx_d;
            act_irq_tx <= tx_d;
            act_trig_a <= ta_d;
            act_trig_b <= tb_d;
            act_prio   <= pr_d;
        end
    end
endmodule

// File: rtl/word_action_ctl.sv
module word_action_ctl
    import wac_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_mode,
    input  logic              irq_override,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [LANES-1:0]  host_be,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              net_we,
    input  logic [IDX_W-1:0]  net_addr,
    input  logic [LANES-1:0]  net_be,
    input  logic [DATA_W-1:0] net_wdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              act_irq_rx,
    output logic              act_irq_tx,
    output logic              act_trig_a,
    output logic              act_trig_b,
    output logic              act_prio
);
    field_t fld_host, fld_net, fld_wval;
    logic   fld_wen, host_dw, net_dw;

    wac_field_store #(.WORDS(WORDS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fld_wen),
        .wr_idx   (host_addr),
        .wr_val   (fld_wval),
        .rd_a_idx (host_addr),
        .rd_a_val (fld_host),
        .rd_b_idx (net_addr),
        .rd_b_val (fld_net)
    );

    wac_access_steer #(.IDX_W(IDX_W)) u_steer (
        .clk          (clk),
        .rst_n        (rst_n),
        .field_mode   (field_mode),
        .host_req     (host_req),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_be      (host_be),
        .host_wdata   (host_wdata),
        .host_ready   (host_ready),
        .host_rvalid  (host_rvalid),
        .host_rdata   (host_rdata),
        .net_we       (net_we),
        .net_addr     (net_addr),
        .net_be       (net_be),
        .net_wdata    (net_wdata),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_be       (mem_be),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .fld_host_val (fld_host),
        .fld_wr_en    (fld_wen),
        .fld_wr_val   (fld_wval),
        .host_data_wr (host_dw),
        .net_data_wr  (net_dw)
    );

    wac_action_decode u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_override (irq_override),
        .host_v       (host_dw),
        .host_fld     (fld_host),
        .net_v        (net_dw),
        .net_fld      (fld_net),
        .act_irq_rx   (act_irq_rx),
        .act_irq_tx   (act_irq_tx),
        .act_trig_a   (act_trig_a),
        .act_trig_b   (act_trig_b),
        .act_prio     (act_prio)
    );
endmodule

// File: rtl/wac_checker.sv
module wac_checker
    import wac_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             field_mode,
    input logic             host_req,
    input logic             host_we,
    input logic [LANES-1:0] host_be,
    input logic             host_ready,
    input logic             host_rvalid,
    input logic             net_we,
    input logic [LANES-1:0] net_be,
    input logic             mem_en,
    input logic             act_irq_rx,
    input logic             act_irq_tx,
    input logic             act_trig_a,
    input logic             act_trig_b,
    input logic             act_prio
);
    logic host_wr_seen, net_wr_seen;
    assign host_wr_seen = host_req && host_ready && host_we && !field_mode && (|host_be);
    assign net_wr_seen  = net_we && (|net_be);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!act_irq_rx && !act_irq_tx && !act_trig_a
                                           && !act_trig_b && !act_prio);
        end
    end

    assert_field_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (field_mode && !net_we) |-> !mem_en);

    assert_read_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && !host_we) |=> host_rvalid);

    assert_read_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    assert_rx_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !net_wr_seen |=> !act_irq_rx);

    assert_tx_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr_seen |=> !act_irq_tx);

    assert_no_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr_seen || net_wr_seen) |=> !(act_trig_a || act_trig_b || act_prio));

    assert_net_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (net_we && !field_mode) |-> !host_ready);
endmodule

bind word_action_ctl wac_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_mode  (field_mode),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_be     (host_be),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .net_we      (net_we),
    .net_be      (net_be),
    .mem_en      (mem_en),
    .act_irq_rx  (act_irq_rx),
    .act_irq_tx  (act_irq_tx),
    .act_trig_a  (act_trig_a),
    .act_trig_b  (act_trig_b),
    .act_prio    (act_prio)
);

// File: tb/sim_word_action_ctl.sv
`timescale 1ns/1ps
module sim_word_action_ctl;
    localparam int WORDS = 64;
    localparam int IW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          field_mode = 1'b0, irq_override = 1'b0;
    logic          host_req = 1'b0, host_we = 1'b0;
    logic [IW-1:0] host_addr = '0;
    logic [3:0]    host_be = '0;
    logic [31:0]   host_wdata = '0;
    logic          host_ready, host_rvalid;
    logic [31:0]   host_rdata;
    logic          net_we = 1'b0;
    logic [IW-1:0] net_addr = '0;
    logic [3:0]    net_be = '0;
    logic [31:0]   net_wdata = '0;
    logic          mem_en, mem_we;
    logic [IW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          act_irq_rx, act_irq_tx, act_trig_a, act_trig_b, act_prio;

    int total = 0;
    int bad   = 0;

    logic [31:0] mem_model [WORDS];
    logic [31:0] sm [WORDS];
    logic [4:0]  sf [WORDS];

    always #4 clk = ~clk;

    word_action_ctl #(.WORDS(WORDS)) u0 (.*);

    // External shared memory with a one-cycle read
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem_model[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem_model[mem_addr];
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // Drives one cycle of stimulus at a falling edge, then checks the results and one quiet cycle.
    task automatic step(input logic hreq, input logic hwe, input logic [IW-1:0] ha, input logic [3:0] hbe,
                        input logic [31:0] hwd, input logic nwe, input logic [IW-1:0] na,
                        input logic [3:0] nbe, input logic [31:0] nwd, input string tag);
        logic e_rdy, acc, hdw, hfw, nw, e_men;
        logic [4:0]  hf, nf;
        logic [31:0] e_rd;
        hf    = sf[ha];
        nf    = sf[na];
        e_rdy = field_mode | ~nwe;
        acc   = hreq & e_rdy;
        hdw   = acc & hwe & ~field_mode & (|hbe);
        hfw   = acc & hwe & field_mode & hbe[0];
        nw    = nwe & (|nbe);
        e_men = nwe | (acc & ~field_mode);
        e_rd  = field_mode ? {27'd0, hf} : sm[ha];
        host_req = hreq; host_we = hwe; host_addr = ha; host_be = hbe; host_wdata = hwd;
        net_we = nwe; net_addr = na; net_be = nbe; net_wdata = nwd;
        #1;
        chk(host_ready === e_rdy, {"R10 host_ready ", tag}, 32'(host_ready), 32'(e_rdy));
        chk(mem_en === e_men, {"R3 mem_en ", tag}, 32'(mem_en), 32'(e_men));
        @(posedge clk);
        @(negedge clk);
        chk(act_irq_rx === (nw & (nf[0] | irq_override)), {"R5/R8 irq_rx ", tag},
            32'(act_irq_rx), 32'(nw & (nf[0] | irq_override)));
        chk(act_irq_tx === (hdw & (hf[1] | irq_override)), {"R5/R8 irq_tx ", tag},
            32'(act_irq_tx), 32'(hdw & (hf[1] | irq_override)));
        chk(act_trig_a === ((nw & nf[2]) | (hdw & hf[2])), {"R6 trig_a ", tag},
            32'(act_trig_a), 32'((nw & nf[2]) | (hdw & hf[2])));
        chk(act_trig_b === ((nw & nf[3]) | (hdw & hf[3])), {"R6 trig_b ", tag},
            32'(act_trig_b), 32'((nw & nf[3]) | (hdw & hf[3])));
        chk(act_prio === ((nw & nf[4]) | (hdw & hf[4])), {"R7 prio ", tag},
            32'(act_prio), 32'((nw & nf[4]) | (hdw & hf[4])));
        if (acc && !hwe) begin
            chk(host_rvalid === 1'b1, {"R4 rvalid ", tag}, 32'(host_rvalid), 32'd1);
            chk(host_rdata === e_rd, {field_mode ? "R2 field read " : "R4 mem read ", tag},
                host_rdata, e_rd);
        end
        host_req = 1'b0; host_we = 1'b0; net_we = 1'b0; host_be = '0; net_be = '0;
        if (nw)  for (int b = 0; b < 4; b++) if (nbe[b]) sm[na][8*b +: 8] = nwd[8*b +: 8];
        if (hdw) for (int b = 0; b < 4; b++) if (hbe[b]) sm[ha][8*b +: 8] = hwd[8*b +: 8];
        if (hfw) sf[ha] = hwd[4:0];
        @(posedge clk);
        @(negedge clk);
        chk({act_irq_rx, act_irq_tx, act_trig_a, act_trig_b, act_prio, host_rvalid} === 6'd0,
            {"R6 single-cycle pulse ", tag},
            32'({act_irq_rx, act_irq_tx, act_trig_a, act_trig_b, act_prio, host_rvalid}), 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [IW-1:0] a;
        logic [IW-1:0] b;
        int kind;
        for (int i = 0; i < WORDS; i++) begin
            mem_model[i] = '0; sm[i] = '0; sf[i] = '0;
        end
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs and an open host window after reset
        chk({act_irq_rx, act_irq_tx, act_trig_a, act_trig_b, act_prio} === 5'd0, "R1 actions after reset",
            32'({act_irq_rx, act_irq_tx, act_trig_a, act_trig_b, act_prio}), 32'd0);
        chk(host_ready === 1'b1, "R1 ready after reset", 32'(host_ready), 32'd1);
        field_mode = 1'b1;
        step(1, 0, 6'd3, 4'h0, 32'h0, 0, 6'd0, 4'h0, 32'h0, "R1 mask reads zero");
        // R2: only lane 0 reaches a mask
        step(1, 1, 6'd5, 4'hE, 32'hFFFF_FF1F, 0, 6'd0, 4'h0, 32'h0, "R2 upper lanes ignored");
        step(1, 0, 6'd5, 4'h0, 32'h0, 0, 6'd0, 4'h0, 32'h0, "R2 read unchanged");
        step(1, 1, 6'd5, 4'h1, 32'hFFFF_FFF5, 0, 6'd0, 4'h0, 32'h0, "R2 store low bits");
        step(1, 0, 6'd5, 4'h0, 32'h0, 0, 6'd0, 4'h0, 32'h0, "R2 read back");
        // R9: masks stay in force after leaving field mode; reads now reach memory
        field_mode = 1'b0;
        step(1, 1, 6'd5, 4'h4, 32'h00AB_0000, 0, 6'd0, 4'h0, 32'h0, "R9 host write actions");
        step(0, 0, 6'd0, 4'h0, 32'h0, 1, 6'd5, 4'h3, 32'h0000_1234, "R9 net write actions");
        step(1, 0, 6'd5, 4'h0, 32'h0, 0, 6'd0, 4'h0, 32'h0, "R9 read memory not mask");
        // R12: no enables, no action
        step(1, 1, 6'd5, 4'h0, 32'hDEAD_BEEF, 0, 6'd0, 4'h0, 32'h0, "R12 empty enables");
        // R8: override on a blank word
        irq_override = 1'b1;
        step(0, 0, 6'd0, 4'h0, 32'h0, 1, 6'd6, 4'h1, 32'h77, "R8 override rx");
        step(1, 1, 6'd6, 4'h1, 32'h55, 0, 6'd0, 4'h0, 32'h0, "R8 override tx");
        irq_override = 1'b0;
        // R11: mask update and network write to the same word in one cycle
        field_mode = 1'b1;
        step(1, 1, 6'd5, 4'h1, 32'h0A, 1, 6'd5, 4'hF, 32'h1111_2222, "R11 collide uses old mask");
        step(0, 0, 6'd0, 4'h0, 32'h0, 1, 6'd5, 4'h8, 32'h3300_0000, "R11 new mask applies");
        // R10: network wins the memory port in normal mode
        field_mode = 1'b0;
        step(1, 1, 6'd5, 4'hF, 32'hCAFE_F00D, 1, 6'd7, 4'hF, 32'h0BAD_0BAD, "R10 host held off");
        step(1, 0, 6'd5, 4'h0, 32'h0, 0, 6'd0, 4'h0, 32'h0, "R10 host write dropped");
        // Constrained random mix over eight words
        for (int it = 0; it < 600; it++) begin
            field_mode   = ($urandom % 3) == 0;
            irq_override = ($urandom % 10) == 0;
            a    = IW'($urandom % 8);
            b    = IW'($urandom % 8);
            kind = $urandom % 5;
            case (kind)
                0: step(1, 1, a, 4'($urandom), $urandom, 0, b, 4'h0, 32'h0, "rand host write");
                1: step(1, 0, a, 4'h0, 32'h0, 0, b, 4'h0, 32'h0, "rand host read");
                2: step(0, 0, a, 4'h0, 32'h0, 1, b, 4'($urandom), $urandom, "rand net write");
                3: step(1, 1, a, 4'($urandom), $urandom, 1, b, 4'($urandom), $urandom, "rand both write");
                default: step(1, 0, a, 4'h0, 32'h0, 1, a, 4'hF, $urandom, "rand read vs net");
            endcase
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule